// File: doc/BRIEF.md
# Key-Entry Reset Detector

This block watches a small group of key input pins and raises a one-cycle system reset request when every pin in a chosen combination is held low at the same time. A 2-bit selector picks the combination, and a selector of zero turns the function off. A pin whose input buffer is disabled can never count as pressed. All raw pins first pass through a two-flop synchronizer. The synchronized levels are also brought out unchanged as the general-purpose input data, so a key used for reset stays readable by software.

Each key pin has its own chattering filter. Without the filter, the request follows as soon as the synchronized all-low condition appears. With the filter enabled on a pin, that pin counts as low only after its synchronized level has stayed low for one cycle more than the programmed filter length. A pin that returns high reloads its filter. After a request the detector stays quiet until at least one participating pin returns high. The filter time base and the reset sequencing that follows the request are outside this block. `rst_n` is asynchronous and is assumed to be released synchronously to `clk`.

Top module: `keyrst_detect`

## Requirements
- R1: `key_sel` chooses the participating pins: 2'b01 selects pins 0 and 1, 2'b10 selects pins 0 to 2, 2'b11 selects pins 0 to 3. `rst_req` pulses only when all participating pins are low at the same time. 2'b00 never produces a request.
- R2: A participating pin whose `key_ien` bit is 0 never counts as low, so no request can occur while it is disabled.
- R3: Pins outside the selected combination, including their `key_ien` and `key_flt_en` bits, have no effect on the request.
- R4: When no participating pin has its filter enabled, `rst_req` goes high after the third rising edge that samples the all-low raw levels. This covers two synchronizer stages and one output register.
- R5: A pin with its `key_flt_en` bit at 1 counts as low only after its synchronized level has been low for `flt_len`+1 consecutive cycles. A single high sample restarts the count.
- R6: When only some participating pins are filtered, the request waits for the slowest filtered pin. With `flt_len` = N on any filtered participant, the request rises N edges later than in R4.
- R7: While `rst_n` is low, `rst_req` is 0 and `pin_in` reads all ones.
- R8: `rst_req` is high for exactly one cycle. It does not assert again while the participating pins stay low, and it re-arms once any participating pin is sampled high.
- R9: `pin_in` equals `pin_raw` delayed by two rising edges, whether or not the pin takes part in key reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | NPINS | Raw pin levels |
| key_ien | input | 4 | Input-buffer enable of key pins 0 to 3 |
| key_sel | input | 2 | Key combination selector |
| key_flt_en | input | 4 | Chattering filter enable of key pins 0 to 3 |
| flt_len | input | FLT_W | Filter length in cycles |
| pin_in | output | NPINS | Synchronized pin levels for the input data path |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The detector is driven with every combination setting, using three kinds of pin pattern. Full-low patterns must fire. Patterns with one participating pin high must not fire, which separates the selector decodes from each other. Patterns where only a non-participating pin is held, disabled or filtered show that the masking works. Filter lengths of zero, a mixed set of filtered pins and several nonzero lengths pin down the exact cycle of the request. Low pulses one cycle short of and exactly at the filter threshold, a single-cycle high glitch, and a release followed by a second press separate the counter reload from the saturation limit and from the re-arm rule.

// File: rtl/keyrst_pkg.sv
package keyrst_pkg;

  localparam int KEY_PINS = 4;

  typedef enum logic [1:0] {
    KSEL_OFF   = 2'b00,
    KSEL_P01   = 2'b01,
    KSEL_P012  = 2'b10,
    KSEL_P0123 = 2'b11
  } ksel_e;

  // Participating-pin mask for a selector value
  function automatic logic [KEY_PINS-1:0] ksel_mask(input logic [1:0] sel);
    logic [KEY_PINS-1:0] m;
    case (sel)
      KSEL_P01:   m = 4'b0011;
      KSEL_P012:  m = 4'b0111;
      KSEL_P0123: m = 4'b1111;
      default:    m = 4'b0000;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/keyrst_sync2.sv
module keyrst_sync2 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);

  logic [W-1:0] st1_q, st2_q;

  // Pins idle high, so reset both stages to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_q <= '1;
      st2_q <= '1;
    end else begin
      st1_q <= d_in;
      st2_q <= st1_q;
    end
  end

  assign q_out = st2_q;

endmodule

// File: rtl/keyrst_filter.sv
module keyrst_filter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_lvl,
  input  logic             flt_on,
  input  logic [CNT_W-1:0] flt_len,
  output logic             low_q
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;
  logic             sat;

  assign sat    = (cnt_q >= flt_len);
  assign cnt_ce = pin_lvl | ~sat;

  always_comb begin
    cnt_d = cnt_q;
    if (pin_lvl)
      cnt_d = '0;
    else if (!sat)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_ce)
      cnt_q <= cnt_d;
  end

  assign low_q = ~pin_lvl & (~flt_on | sat);

  // R5: a filtered low with a nonzero length needs a low sample one cycle earlier
  a_r5_needs_history: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_on && flt_len != '0 && low_q) |-> $past(!pin_lvl));

  // R5: a high sample restarts the count
  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    pin_lvl |=> (cnt_q == '0));

endmodule

// File: rtl/keyrst_detect.sv
module keyrst_detect
  import keyrst_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int FLT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPINS-1:0]    pin_raw,
  input  logic [KEY_PINS-1:0] key_ien,
  input  logic [1:0]          key_sel,
  input  logic [KEY_PINS-1:0] key_flt_en,
  input  logic [FLT_W-1:0]    flt_len,
  output logic [NPINS-1:0]    pin_in,
  output logic                rst_req
);

  logic [KEY_PINS-1:0] mask;
  logic [KEY_PINS-1:0] flt_low;
  logic [KEY_PINS-1:0] key_ok;
  logic                all_low, any_high, fire;
  logic                armed_q, armed_d;
  logic                req_d;

  keyrst_sync2 #(.W(NPINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (pin_raw),
    .q_out (pin_in)
  );

  for (genvar k = 0; k < KEY_PINS; k++) begin : g_flt
    keyrst_filter #(.CNT_W(FLT_W)) u_flt (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_lvl (pin_in[k]),
      .flt_on  (key_flt_en[k]),
      .flt_len (flt_len),
      .low_q   (flt_low[k])
    );
  end

  assign mask     = ksel_mask(key_sel);
  assign key_ok   = key_ien & flt_low;
  assign all_low  = (|mask) & (&(key_ok | ~mask));
  assign any_high = |(mask & pin_in[KEY_PINS-1:0]);
  assign fire     = all_low & armed_q;

  always_comb begin
    armed_d = armed_q;
    if (fire)
      armed_d = 1'b0;
    else if (any_high)
      armed_d = 1'b1;
    req_d = fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      rst_req <= 1'b0;
    end else begin
      armed_q <= armed_d;
      rst_req <= req_d;
    end
  end

  // R8: single-cycle pulse
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R1: no request from a disabled selector
  a_r1_sel_active: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ($past(key_sel) != KSEL_OFF));

  // R2: every participating pin had its input buffer on
  a_r2_ien_on: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (&($past(key_ien) | ~ksel_mask($past(key_sel)))));

  // R1: every participating synchronized pin was low
  a_r1_all_low: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (($past(pin_in[KEY_PINS-1:0]) & ksel_mask($past(key_sel))) == '0));

endmodule

// File: tb/keyrst_detect_bench.sv
`timescale 1ns/1ps
module keyrst_detect_bench;

  localparam int NPINS = 8;
  localparam int FLT_W = 8;
  localparam int NVEC  = 14;
  localparam int WIN   = 40;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NPINS-1:0] pin_raw;
  logic [3:0]       key_ien;
  logic [1:0]       key_sel;
  logic [3:0]       key_flt_en;
  logic [FLT_W-1:0] flt_len;
  logic [NPINS-1:0] pin_in;
  logic             rst_req;

  int nchk  = 0;
  int nfail = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  keyrst_detect #(.NPINS(NPINS), .FLT_W(FLT_W)) u_keyrst_detect (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .key_ien(key_ien),
    .key_sel(key_sel), .key_flt_en(key_flt_en), .flt_len(flt_len),
    .pin_in(pin_in), .rst_req(rst_req)
  );

  // {sel, ien, flt_en, flt_len, pin levels [3:0], expected first-pulse cycle (0 = none)}
  localparam logic [29:0] VEC [NVEC] = '{
    {2'd1, 4'hF, 4'h0,  8'd0, 4'b1100,  8'd3},
    {2'd1, 4'hF, 4'h0,  8'd0, 4'b1110,  8'd0},
    {2'd2, 4'hF, 4'h0,  8'd0, 4'b1000,  8'd3},
    {2'd2, 4'hF, 4'h0,  8'd0, 4'b1100,  8'd0},
    {2'd3, 4'hF, 4'h0,  8'd0, 4'b0000,  8'd3},
    {2'd3, 4'hF, 4'h0,  8'd0, 4'b1000,  8'd0},
    {2'd0, 4'hF, 4'h0,  8'd0, 4'b0000,  8'd0},
    {2'd1, 4'hE, 4'h0,  8'd0, 4'b0000,  8'd0},
    {2'd1, 4'hF, 4'h3,  8'd5, 4'b1100,  8'd8},
    {2'd3, 4'hF, 4'hF, 8'd10, 4'b0000, 8'd13},
    {2'd2, 4'hF, 4'h1,  8'd7, 4'b1000, 8'd10},
    {2'd3, 4'hF, 4'hF,  8'd0, 4'b0000,  8'd3},
    {2'd1, 4'hB, 4'h0,  8'd0, 4'b0000,  8'd3},
    {2'd1, 4'hF, 4'h4, 8'd20, 4'b0000,  8'd3}
  };
  localparam string VTAG [NVEC] = '{
    "R1", "R1", "R1", "R1", "R1", "R1", "R1",
    "R2", "R5", "R5", "R6", "R4", "R3", "R3"
  };

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle_cfg(input logic [1:0] s, input logic [3:0] ien,
                          input logic [3:0] fen, input logic [7:0] len);
    @(negedge clk);
    pin_raw    = '1;
    key_sel    = s;
    key_ien    = ien;
    key_flt_en = fen;
    flt_len    = len;
    repeat (WIN) @(negedge clk);
  endtask

  // Hold the masked pins low for len cycles, then count pulses
  task automatic low_burst(input int len, input logic [3:0] lowmask, output int pulses);
    pulses = 0;
    pin_raw[3:0] = ~lowmask;
    for (int i = 1; i <= len + 12; i++) begin
      @(negedge clk);
      if (rst_req) pulses++;
      if (i == len) pin_raw[3:0] = 4'hF;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int pulses, first;
    logic [29:0] v;
    rst_n = 1'b0;
    pin_raw = '0;
    key_sel = 2'd3; key_ien = 4'hF; key_flt_en = 4'h0; flt_len = '0;
    repeat (3) @(negedge clk);
    // R7: reset state
    chk("R7", int'(rst_req), 0);
    chk("R7", int'(pin_in), 8'hFF);
    pin_raw = '1;
    @(negedge clk);
    rst_n = 1'b1;

    for (int n = 0; n < NVEC; n++) begin
      v = VEC[n];
      idle_cfg(v[29:28], v[27:24], v[23:20], v[19:12]);
      pin_raw[3:0] = v[11:8];
      pulses = 0; first = 0;
      for (int i = 1; i <= WIN; i++) begin
        @(negedge clk);
        if (rst_req) begin
          pulses++;
          if (first == 0) first = i;
        end
      end
      if (v[7:0] == 8'd0) chk(VTAG[n], pulses, 0);
      else begin
        chk(VTAG[n], first, int'(v[7:0]));
        chk("R8", pulses, 1);
      end
    end

    // R5: threshold boundary with flt_len = 4
    idle_cfg(2'd1, 4'hF, 4'h3, 8'd4);
    low_burst(4, 4'b0011, pulses);
    chk("R5", pulses, 0);
    low_burst(5, 4'b0011, pulses);
    chk("R5", pulses, 1);

    // R5: one high glitch restarts the count
    idle_cfg(2'd1, 4'hF, 4'h3, 8'd6);
    pin_raw[3:0] = 4'b1100;
    pulses = 0;
    for (int i = 1; i <= 25; i++) begin
      @(negedge clk);
      if (rst_req) pulses++;
      if (i == 4) pin_raw[1] = 1'b1;
      if (i == 5) pin_raw[1] = 1'b0;
      if (i == 9) pin_raw[3:0] = 4'hF;
    end
    chk("R5", pulses, 0);

    // R8: re-arm after a participating pin returns high
    idle_cfg(2'd1, 4'hF, 4'h0, 8'd0);
    low_burst(10, 4'b0011, pulses);
    chk("R8", pulses, 1);
    pin_raw[3:0] = 4'b1100;
    pulses = 0;
    for (int i = 1; i <= 25; i++) begin
      @(negedge clk);
      if (rst_req) pulses++;
      if (i == 10) pin_raw[1] = 1'b1;
      if (i == 14) pin_raw[1] = 1'b0;
    end
    chk("R8", pulses, 2);

    // R9: data path latency while pins are in key use
    idle_cfg(2'd3, 4'hF, 4'h0, 8'd0);
    pin_raw = 8'hA5;
    @(negedge clk);
    chk("R9", int'(pin_in), 8'hFF);
    @(negedge clk);
    chk("R9", int'(pin_in), 8'hA5);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule